// File: doc/BRIEF.md
# Vector Lane Array with Shared Multipliers

This block is the execution stage of a vector unit. It has `LANES` parallel lanes. Every lane has its own integer ALU, but only `MUL_LANES` multipliers are built, and the lanes share them. An operation is issued with one operand element per lane and an active vector length. Add, subtract and the bitwise operations run in every lane at once, and their results appear one cycle later.

A multiply is split into groups of `MUL_LANES` consecutive lanes. The groups go through the shared multipliers one after another, one group per cycle. While this happens the block raises `busy`, and the issuing side must hold the next operation back until `busy` is low.

When `MUL_LANES` equals `LANES`, a multiply behaves like an ALU operation and never stalls. Lanes at or above the active vector length are masked: they return zero data and are not marked valid.

Top module: `hetlane_array`

## Requirements
- R1: While reset is asserted, and in the cycle after reset, `busy`, `res_valid` and every bit of `res_lane_valid` are low.
- R2: The opcodes are 0 for add, 1 for subtract, 2 for AND, 3 for OR and 4 for XOR, all modulo 2^DW. An operation is accepted on a rising edge where `issue_valid` is high and `busy` is low. One of these five opcodes makes `res_valid` high in the cycle after that edge, with every active lane's result, and leaves `busy` low.
- R3: Opcode 5 is an unsigned multiply that keeps the low DW bits of the product. If PASSES = ceil(LANES/MUL_LANES) is greater than 1, `busy` is high for exactly PASSES cycles after the accepting edge. `res_valid` rises in the cycle `busy` falls, which is PASSES+1 cycles after acceptance.
- R4: In multiply pass p, lanes p*MUL_LANES up to p*MUL_LANES+MUL_LANES-1 are routed to multipliers 0 to MUL_LANES-1. In a final partial group, the multiplier positions past the last lane are unused, and every lane, including those in a partial group, receives its correct product.
- R5: While `busy` is high, `issue_valid` is ignored. A multiply's results are not affected by operands presented during its passes, and no extra result follows.
- R6: When MUL_LANES equals LANES, a multiply completes like an ALU operation: `res_valid` is high one cycle after acceptance and `busy` never rises.
- R7: Lane i is active when i < `issue_vlen`. A length above LANES acts as LANES. An inactive lane returns zero data with its `res_lane_valid` bit low.
- R8: `res_valid` is a single-cycle pulse per completed operation, and `res_lane_valid` is all zero whenever `res_valid` is low.
- R9: Opcodes 6 and 7 complete as ALU operations with zero data in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is offered |
| issue_op | input | 3 | Opcode |
| issue_vlen | input | $clog2(LANES+1) | Active vector length |
| issue_a | input | LANES*DW | First operand, lane i in bits i*DW and up |
| issue_b | input | LANES*DW | Second operand, same packing |
| busy | output | 1 | Multiply passes in progress, issue is stalled |
| res_valid | output | 1 | Results are present this cycle |
| res_lane_valid | output | LANES | Per-lane result valid |
| res_data | output | LANES*DW | Per-lane results |

## Verification
A routing fault, where a pass counter or group select is wrong, shows up as wrong products in one whole lane group, and it does so in the cycle `res_valid` rises. For that reason the bench checks every lane separately, with a vector length that ends inside the partial last group. A sequencing fault moves the `res_valid` pulse or changes the length of `busy` by at least one cycle. The bench counts those cycles exactly for every operation. A stall that leaks, where an operation is accepted while `busy` is high, appears as a second `res_valid` pulse right after the first, or as products made from the wrong operands.

// File: rtl/hetlane_pkg.sv
`timescale 1ns/1ps
package hetlane_pkg;
  localparam int HL_OPW = 3;
  typedef enum logic [HL_OPW-1:0] {
    HL_ADD = 3'd0,
    HL_SUB = 3'd1,
    HL_AND = 3'd2,
    HL_OR  = 3'd3,
    HL_XOR = 3'd4,
    HL_MUL = 3'd5
  } hl_op_e;
endpackage

// File: rtl/hetlane_alu.sv
`timescale 1ns/1ps
module hetlane_alu
  import hetlane_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [HL_OPW-1:0] op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [DW-1:0]     y
);
  // Multiply and unused codes give zero here; products come from the shared units.
  always_comb begin
    case (hl_op_e'(op))
      HL_ADD:  y = a + b;
      HL_SUB:  y = a - b;
      HL_AND:  y = a & b;
      HL_OR:   y = a | b;
      HL_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/hetlane_mul.sv
`timescale 1ns/1ps
module hetlane_mul #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  assign y = a * b;
endmodule

// File: rtl/hetlane_route.sv
`timescale 1ns/1ps
module hetlane_route #(
  parameter  int LANES     = 8,
  parameter  int MUL_LANES = 3,
  parameter  int DW        = 16,
  localparam int PASSES    = (LANES + MUL_LANES - 1) / MUL_LANES,
  localparam int PW        = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [PW-1:0]           group,
  input  logic [LANES*DW-1:0]     src_a,
  input  logic [LANES*DW-1:0]     src_b,
  input  logic [MUL_LANES*DW-1:0] prod,
  output logic [MUL_LANES*DW-1:0] mul_a,
  output logic [MUL_LANES*DW-1:0] mul_b,
  output logic [LANES*DW-1:0]     lane_prod,
  output logic [LANES-1:0]        lane_wr
);
  localparam int PADW = PASSES * MUL_LANES * DW;

  logic [PADW-1:0] pad_a;
  logic [PADW-1:0] pad_b;

  // Zero padding keeps the partial last group in range.
  assign pad_a = PADW'(src_a);
  assign pad_b = PADW'(src_b);

  for (genvar j = 0; j < MUL_LANES; j++) begin : g_unit
    assign mul_a[j*DW +: DW] = pad_a[(int'(group) * MUL_LANES + j) * DW +: DW];
    assign mul_b[j*DW +: DW] = pad_b[(int'(group) * MUL_LANES + j) * DW +: DW];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_prod[i*DW +: DW] = prod[(i % MUL_LANES) * DW +: DW];
    assign lane_wr[i]            = en && (group == PW'(i / MUL_LANES));
  end

  // R4
  grp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (int'(group) < PASSES));

  // R4
  wr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(lane_wr) >= 1 && $countones(lane_wr) <= MUL_LANES));
endmodule

// File: rtl/hetlane_seq.sv
`timescale 1ns/1ps
module hetlane_seq #(
  parameter  int PASSES = 3,
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic          issue_mul,
  output logic          accept,
  output logic          busy,
  output logic [PW-1:0] pass_idx,
  output logic          res_valid
);
  localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] pass_q, pass_d;
  logic          rv_q, rv_d;

  assign accept = issue_valid & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    pass_d = pass_q;
    rv_d   = 1'b0;
    if (accept) begin
      if (issue_mul && (PASSES > 1)) begin
        busy_d = 1'b1;
        pass_d = '0;
      end else begin
        rv_d = 1'b1;
      end
    end else if (busy_q) begin
      if (pass_q == LAST) begin
        busy_d = 1'b0;
        pass_d = '0;
        rv_d   = 1'b1;
      end else begin
        pass_d = pass_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pass_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pass_q <= pass_d;
      rv_q   <= rv_d;
    end
  end

  assign busy      = busy_q;
  assign pass_idx  = pass_q;
  assign res_valid = rv_q;

  // R3
  last_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pass_q == LAST) |=> (!busy_q && rv_q));

  // R4
  pass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(pass_q) < PASSES));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pass_q != LAST) |=> (busy_q && pass_q == $past(pass_q) + 1'b1));
endmodule

// File: rtl/hetlane_array.sv
`timescale 1ns/1ps
module hetlane_array
  import hetlane_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int MUL_LANES = 3,
  parameter int DW        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue_valid,
  input  logic [HL_OPW-1:0]          issue_op,
  input  logic [$clog2(LANES+1)-1:0] issue_vlen,
  input  logic [LANES*DW-1:0]        issue_a,
  input  logic [LANES*DW-1:0]        issue_b,
  output logic                       busy,
  output logic                       res_valid,
  output logic [LANES-1:0]           res_lane_valid,
  output logic [LANES*DW-1:0]        res_data
);
  localparam int PASSES = (LANES + MUL_LANES - 1) / MUL_LANES;
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam int VW     = $clog2(LANES + 1);
  localparam int LW     = LANES * DW;
  localparam int MW     = MUL_LANES * DW;
  localparam bit ONE_PASS = (PASSES == 1);

  logic          is_mul;
  logic          accept_w, busy_w, res_valid_w;
  logic [PW-1:0] pass_w;
  logic [LANES-1:0] issue_mask, mask_eff;
  logic [LW-1:0] a_q, a_d, b_q, b_d;
  logic [LANES-1:0] mask_q, mask_d;
  logic [LW-1:0] res_q, res_d;
  logic [LW-1:0] alu_y, lane_prod, src_a, src_b;
  logic [MW-1:0] mul_a, mul_b, prod;
  logic [LANES-1:0] lane_wr;
  logic          route_en, alu_load;
  logic [PW-1:0] group;

  assign is_mul = (issue_op == HL_MUL);

  hetlane_seq #(.PASSES(PASSES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_mul   (is_mul),
    .accept      (accept_w),
    .busy        (busy_w),
    .pass_idx    (pass_w),
    .res_valid   (res_valid_w)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign issue_mask[i] = (VW'(i) < issue_vlen);
  end

  // Operand capture, enabled on acceptance.
  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    mask_d = mask_q;
    if (accept_w) begin
      a_d    = issue_a;
      b_d    = issue_b;
      mask_d = issue_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mask_q <= '0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      mask_q <= mask_d;
    end
  end

  // Single-pass multiplies take operands straight from the issue port.
  assign route_en = busy_w | (accept_w & is_mul & ONE_PASS);
  assign alu_load = accept_w & ~is_mul;
  assign src_a    = busy_w ? a_q : issue_a;
  assign src_b    = busy_w ? b_q : issue_b;
  assign group    = busy_w ? pass_w : '0;
  assign mask_eff = busy_w ? mask_q : issue_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_alu
    hetlane_alu #(.DW(DW)) u_alu (
      .op (issue_op),
      .a  (issue_a[i*DW +: DW]),
      .b  (issue_b[i*DW +: DW]),
      .y  (alu_y[i*DW +: DW])
    );
  end

  hetlane_route #(.LANES(LANES), .MUL_LANES(MUL_LANES), .DW(DW)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (route_en),
    .group     (group),
    .src_a     (src_a),
    .src_b     (src_b),
    .prod      (prod),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .lane_prod (lane_prod),
    .lane_wr   (lane_wr)
  );

  for (genvar j = 0; j < MUL_LANES; j++) begin : g_mul
    hetlane_mul #(.DW(DW)) u_mul (
      .a (mul_a[j*DW +: DW]),
      .b (mul_b[j*DW +: DW]),
      .y (prod[j*DW +: DW])
    );
  end

  // Result registers, one DW slice per lane.
  always_comb begin
    res_d = res_q;
    for (int i = 0; i < LANES; i++) begin
      if (alu_load) begin
        res_d[i*DW +: DW] = issue_mask[i] ? alu_y[i*DW +: DW] : '0;
      end else if (lane_wr[i]) begin
        res_d[i*DW +: DW] = mask_eff[i] ? lane_prod[i*DW +: DW] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign busy           = busy_w;
  assign res_valid      = res_valid_w;
  assign res_lane_valid = mask_q & {LANES{res_valid_w}};
  assign res_data       = res_q;

  // R3
  mul_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> $past(issue_valid && is_mul));

  // R5
  ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> ($stable(a_q) && $stable(b_q) && $stable(mask_q)));

  if (ONE_PASS) begin : g_one
    // R6
    single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_w);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mchk
    // R7
    masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_w && !res_lane_valid[i]) |-> (res_q[i*DW +: DW] == '0));
  end
endmodule

// File: tb/hetlane_array_bench.sv
`timescale 1ns/1ps
module hetlane_array_bench;
  localparam int L  = 8;
  localparam int X  = 3;
  localparam int DW = 16;
  localparam int PASSES = (L + X - 1) / X;
  localparam int NV = 10;

  localparam logic [2:0]  T_OP   [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd5, 3'd6, 3'd5};
  localparam logic [3:0]  T_VL   [NV] = '{4'd8, 4'd8, 4'd5, 4'd3, 4'd8, 4'd8, 4'd7, 4'd12, 4'd8, 4'd0};
  localparam logic [15:0] T_SEED [NV] = '{16'h04D2, 16'h0007, 16'hBEEF, 16'h1357, 16'hA5A5,
                                          16'h0123, 16'h7FFF, 16'h00FF, 16'h0055, 16'h0042};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [2:0] issue_op = '0;
  logic [3:0] issue_vlen = '0;
  logic [L*DW-1:0] issue_a = '0, issue_b = '0;
  logic busy, res_valid;
  logic [L-1:0] res_lane_valid;
  logic [L*DW-1:0] res_data;

  logic f_issue_valid = 1'b0;
  logic [2:0] f_issue_op = '0;
  logic [3:0] f_issue_vlen = '0;
  logic [L*DW-1:0] f_issue_a = '0, f_issue_b = '0;
  logic f_busy, f_res_valid;
  logic [L-1:0] f_res_lane_valid;
  logic [L*DW-1:0] f_res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hetlane_array #(.LANES(L), .MUL_LANES(X), .DW(DW)) u_hetlane_array (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_vlen(issue_vlen), .issue_a(issue_a), .issue_b(issue_b), .busy(busy),
    .res_valid(res_valid), .res_lane_valid(res_lane_valid), .res_data(res_data));

  hetlane_array #(.LANES(L), .MUL_LANES(L), .DW(DW)) u_hetlane_array_full (
    .clk(clk), .rst_n(rst_n), .issue_valid(f_issue_valid), .issue_op(f_issue_op),
    .issue_vlen(f_issue_vlen), .issue_a(f_issue_a), .issue_b(f_issue_b), .busy(f_busy),
    .res_valid(f_res_valid), .res_lane_valid(f_res_lane_valid), .res_data(f_res_data));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L*DW-1:0] mk_a(input logic [15:0] s);
    for (int i = 0; i < L; i++) mk_a[i*DW +: DW] = 16'(s * (i + 7)) + 16'(i * 977);
  endfunction

  function automatic logic [L*DW-1:0] mk_b(input logic [15:0] s);
    for (int i = 0; i < L; i++) mk_b[i*DW +: DW] = (s ^ 16'(i * 3889)) + 16'd3;
  endfunction

  function automatic logic [15:0] ref_lane(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      3'd0: ref_lane = a + b;
      3'd1: ref_lane = a - b;
      3'd2: ref_lane = a & b;
      3'd3: ref_lane = a | b;
      3'd4: ref_lane = a ^ b;
      3'd5: ref_lane = a * b;
      default: ref_lane = 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input int lane);
    if (op == 3'd5) tag_of = (lane >= 2 * X) ? "R4" : "R3";
    else if (op > 3'd5) tag_of = "R9";
    else tag_of = "R2";
  endfunction

  // Issues one operation on the shared-multiplier instance and checks timing and lanes.
  task automatic run_main(input logic [2:0] op, input logic [3:0] vl, input logic [15:0] seed, input bit junk);
    logic [L*DW-1:0] a, b;
    int lat, bz, exp_lat, act_vl;
    a = mk_a(seed);
    b = mk_b(seed);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_vlen = vl; issue_a = a; issue_b = b;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      issue_op = 3'd0; issue_a = ~a; issue_b = ~b; issue_vlen = 4'd8;
    end else begin
      issue_valid = 1'b0;
    end
    lat = 1; bz = 0;
    while (!res_valid && lat < 16) begin
      if (busy) bz++;
      @(negedge clk);
      lat++;
    end
    issue_valid = 1'b0;
    exp_lat = (op == 3'd5) ? PASSES + 1 : 1;
    check(lat == exp_lat, (op == 3'd5) ? "R3 latency" : "R2 latency", lat, exp_lat);
    if (op == 3'd5) check(bz == PASSES, "R3 busy cycles", bz, PASSES);
    else check(bz == 0 && !busy, "R2 no stall", bz, 0);
    act_vl = (vl > L) ? L : int'(vl);
    for (int i = 0; i < L; i++) begin
      logic [15:0] e;
      e = (i < act_vl) ? ref_lane(op, a[i*DW +: DW], b[i*DW +: DW]) : 16'd0;
      check(res_data[i*DW +: DW] == e, (i < act_vl) ? tag_of(op, i) : "R7 data", res_data[i*DW +: DW], e);
      check(res_lane_valid[i] == (i < act_vl), "R7 lane valid", res_lane_valid[i], (i < act_vl));
    end
    @(negedge clk);
    check(!res_valid && res_lane_valid == '0, junk ? "R5 no extra result" : "R8 pulse",
          {res_valid, res_lane_valid}, 0);
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      check(1'b0, "WATCHDOG", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #5;
    check(!busy && !res_valid && res_lane_valid == '0, "R1 in reset", {busy, res_valid, res_lane_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !res_valid && res_lane_valid == '0, "R1 after reset", {busy, res_valid, res_lane_valid}, 0);

    for (int k = 0; k < NV; k++) run_main(T_OP[k], T_VL[k], T_SEED[k], 1'b0);

    // R5: issue attempts while busy are ignored
    run_main(3'd5, 4'd8, 16'h3C3C, 1'b1);
    run_main(3'd5, 4'd6, 16'h9001, 1'b1);

    // R8: back-to-back ALU ops give one pulse each
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 3'd0; issue_vlen = 4'd8; issue_a = mk_a(16'd1); issue_b = mk_b(16'd1);
    @(negedge clk);
    check(res_valid, "R8 first pulse", res_valid, 1);
    issue_op = 3'd4;
    @(negedge clk);
    issue_valid = 1'b0;
    check(res_valid && res_data[DW-1:0] == (16'd7 ^ 16'd4), "R8 second pulse", res_data[DW-1:0], 16'd7 ^ 16'd4);
    @(negedge clk);
    check(!res_valid, "R8 pulse ends", res_valid, 0);

    // R6: full multiplier set never stalls
    @(negedge clk);
    f_issue_valid = 1'b1; f_issue_op = 3'd5; f_issue_vlen = 4'd8;
    f_issue_a = mk_a(16'h0BAD); f_issue_b = mk_b(16'h0BAD);
    @(negedge clk);
    f_issue_valid = 1'b0;
    check(f_res_valid && !f_busy, "R6 single pass", {f_res_valid, f_busy}, 2'b10);
    for (int i = 0; i < L; i++) begin
      logic [15:0] e;
      e = ref_lane(3'd5, f_issue_a[i*DW +: DW], f_issue_b[i*DW +: DW]);
      check(f_res_data[i*DW +: DW] == e, "R6 product", f_res_data[i*DW +: DW], e);
    end

    // R1: reset during multiply passes
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 3'd5; issue_vlen = 4'd8;
    @(negedge clk);
    issue_valid = 1'b0;
    check(busy, "R3 busy raised", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !res_valid && res_lane_valid == '0, "R1 mid-op reset", {busy, res_valid, res_lane_valid}, 0);
    rst_n = 1'b1;
    run_main(3'd1, 4'd8, 16'h2222, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule